// File: doc/BRIEF.md
# Rate-One-Third Convolutional Encoder

The encoder takes a serial message, one bit per accepted handshake, and emits one 3-bit code symbol per message bit. It keeps the present bit and the two bits before it in a three-cell window, and forms each code bit as the exclusive-OR of a fixed subset of those cells. A frame is twelve message bits long. A frame therefore turns into twelve symbols, thirty-six coded bits in all. Each frame opens with a start-of-frame strobe. The strobe zeroes the two history cells, so every frame starts from the all-zero encoder state.

A small frame controller has two states. FR_IDLE waits for a start-of-frame. FR_RUN counts the bits of the frame. The transitions are as follows:
- FR_IDLE to FR_RUN happens on an accepted bit that carries start-of-frame.
- FR_RUN to FR_RUN happens on an accepted bit. The count goes up by one, or restarts at one if the bit carries start-of-frame.
- FR_RUN to FR_IDLE happens on the accepted bit that completes the frame.

In FR_IDLE, a bit without start-of-frame is consumed and discarded. The output is a registered symbol with valid, ready and a done flag. Input is stalled while a symbol waits on a consumer that is not ready.

Top module: `cnv3_enc`

## Requirements
- R1: Each accepted frame bit produces exactly one 3-bit symbol. A complete frame of 12 bits yields 12 symbols (36 coded bits), and no other symbols are produced.
- R2: Bit 2 of `out_sym` (v0) equals m0 XOR m2. Here m0 is the accepted bit, m1 is the previous bit of the frame and m2 is the bit before that.
- R3: Bits 1 and 0 of `out_sym` (v1, v2) each equal m0 XOR m1 XOR m2.
- R4: Each accepted bit shifts the window. m0 moves to m1 and m1 moves to m2, so one bit influences exactly three consecutive symbols. A lone 1 followed by zeros gives the symbols 111, 011, 111, 000.
- R5: A bit accepted with `in_sof` high is encoded with m1 = m2 = 0, whatever the previous frame left behind.
- R6: `out_done` is high exactly with the 12th symbol of a frame, and only while `out_valid` is high.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_sym`, `out_done` and `out_valid` hold their values.
- R8: In FR_IDLE, a bit offered without `in_sof` is accepted and discarded, and no symbol results.
- R9: A start-of-frame in the middle of a frame restarts the frame. The bit count restarts at 1 and the history is cleared.
- R10: After reset, `out_valid` and `out_done` are 0 and `in_ready` is 1.
- R11: A symbol appears on the output in the cycle after the clock edge that accepted its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message bit offered |
| in_bit | input | 1 | Message bit |
| in_sof | input | 1 | Offered bit is the first of a frame |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| out_valid | output | 1 | Code symbol present |
| out_sym | output | 3 | Code symbol {v0, v1, v2} |
| out_done | output | 1 | Symbol is the last of its frame |
| out_ready | input | 1 | Consumer takes the symbol |

## Verification
Two functions can fall in the same cycle: the completion of a frame on its twelfth bit, and a fresh start-of-frame. When a strobe arrives on what would have been the twelfth bit, it must win. The frame restarts with a count of one and no done flag. The random phase raises `in_sof` on about one bit in sixteen, under random valid and ready, so this collision occurs many times. A bench model of the frame count and history then judges every symbol's value and done flag.

// File: rtl/cnv3_pkg.sv
package cnv3_pkg;
    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_t;
endpackage

// File: rtl/cnv3_taps.sv
module cnv3_taps #(
    parameter int unsigned K = 3,
    parameter int unsigned N = 3,
    parameter logic [N*K-1:0] GEN = {3'b101, 3'b111, 3'b111}
) (
    input  logic [K-1:0] win,
    output logic [N-1:0] code
);
    // code[j] is the parity of the window cells selected by generator j
    for (genvar j = 0; j < N; j++) begin : g_tap
        assign code[j] = ^(win & GEN[j*K +: K]);
    end
endmodule

// File: rtl/cnv3_frame_ctl.sv
module cnv3_frame_ctl
    import cnv3_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 12,
    localparam int unsigned CW = $clog2(FRAME_LEN + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  logic      sof,
    output logic      emit,
    output logic      last,
    output fr_state_t state
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = sof ? CW'(1) : cnt + CW'(1);
        emit    = 1'b0;
        unique case (state)
            FR_IDLE: emit = accept && sof;
            FR_RUN:  emit = accept;
            default: emit = 1'b0;
        endcase
        last = emit && (cnt_nxt == CW'(FRAME_LEN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
        end else if (emit) begin
            if (last) begin
                state <= FR_IDLE;
                cnt   <= '0;
            end else begin
                state <= FR_RUN;
                cnt   <= cnt_nxt;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(FRAME_LEN)); // R1
    AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> state == FR_IDLE); // R6
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state == FR_IDLE |-> cnt == '0); // R8
endmodule

// File: rtl/cnv3_enc.sv
module cnv3_enc
    import cnv3_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 12,
    parameter int unsigned K = 3,
    parameter int unsigned N = 3,
    parameter logic [N*K-1:0] GEN = {3'b101, 3'b111, 3'b111},
    localparam int unsigned HW = K - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_bit,
    input  logic         in_sof,
    output logic         in_ready,
    output logic         out_valid,
    output logic [N-1:0] out_sym,
    output logic         out_done,
    input  logic         out_ready
);
    logic          accept;
    logic          emit;
    logic          last;
    fr_state_t     state;
    logic [HW-1:0] hist;   // hist[0] = newest past bit (m1)
    logic [K-1:0]  win;    // win[0] = m0
    logic [N-1:0]  code;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign win      = {(in_sof ? {HW{1'b0}} : hist), in_bit};

    cnv3_frame_ctl #(.FRAME_LEN(FRAME_LEN)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .sof    (in_sof),
        .emit   (emit),
        .last   (last),
        .state  (state)
    );

    cnv3_taps #(.K(K), .N(N), .GEN(GEN)) u_taps (
        .win  (win),
        .code (code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (emit) begin
            hist <= win[HW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
            out_done  <= 1'b0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_sym   <= code;
            out_done  <= last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_done)); // R7
    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R7
    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid); // R6
    AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> out_valid); // R11
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        state == FR_IDLE && accept && !in_sof |=> !out_valid); // R8
endmodule

// File: tb/cnv3_enc_bench.sv
module cnv3_enc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [2:0] out_sym;
    logic       out_done;
    logic       out_ready = 1'b1;

    int total = 0;
    int fails = 0;

    // bench model
    logic       m_run = 1'b0;
    int         m_cnt = 0;
    logic       m1 = 1'b0;
    logic       m2 = 1'b0;
    logic [3:0] exp_q[$];
    logic [2:0] sym_log[$];
    int         nsym = 0;
    logic       prev_stall = 1'b0;
    logic [2:0] held_sym = '0;
    logic       held_done = 1'b0;

    always #5 clk = ~clk;

    cnv3_enc u_cnv3_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_sof(in_sof), .in_ready(in_ready), .out_valid(out_valid),
        .out_sym(out_sym), .out_done(out_done), .out_ready(out_ready)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] enc_sym(input logic b, input logic a1, input logic a2,
                                           input logic dn);
        return {b ^ a2, b ^ a1 ^ a2, b ^ a1 ^ a2, dn};
    endfunction

    // drive at negedge, evaluate just after, then wait for next negedge
    task automatic step(input logic v, input logic b, input logic s, input logic rdy);
        logic [3:0] e;
        in_valid  = v;
        in_bit    = b;
        in_sof    = s;
        out_ready = rdy;
        #1;
        if (prev_stall) begin
            check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
            check(out_sym == held_sym && out_done == held_done, "R7 symbol held",
                  int'({out_sym, out_done}), int'({held_sym, held_done}));
        end
        if (out_valid && !out_ready)
            check(in_ready == 1'b0, "R7 in_ready low", int'(in_ready), 0);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected symbol", int'(out_sym), -1);
            end else begin
                e = exp_q.pop_front();
                check(out_sym[2] == e[3], "R2 v0", int'(out_sym[2]), int'(e[3]));
                check(out_sym[1:0] == e[2:1], "R3 v1v2", int'(out_sym[1:0]), int'(e[2:1]));
                check(out_done == e[0], "R6 done", int'(out_done), int'(e[0]));
            end
            sym_log.push_back(out_sym);
            nsym++;
        end
        if (in_valid && in_ready) begin
            if (in_sof) begin
                m1 = 1'b0; m2 = 1'b0; m_cnt = 1;
            end else if (m_run) begin
                m_cnt++;
            end
            if (in_sof || m_run) begin
                exp_q.push_back(enc_sym(in_bit, m1, m2, m_cnt == 12));
                m2 = m1;
                m1 = in_bit;
                m_run = (m_cnt != 12);
                if (m_cnt == 12) m_cnt = 0;
            end
        end
        prev_stall = out_valid && !out_ready;
        held_sym   = out_sym;
        held_done  = out_done;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 0 && out_done == 0 && in_ready == 1, "R10 reset state",
              int'({out_valid, out_done, in_ready}), 1);
        @(negedge clk);

        // R11 latency and R4 impulse response, R1 frame length
        base = nsym;
        step(1, 1, 1, 1);
        check(out_valid == 1 && out_sym == 3'b111, "R11 latency",
              int'({out_valid, out_sym}), 15);
        for (int i = 0; i < 11; i++) step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        check(nsym - base == 12, "R1 symbols per frame", nsym - base, 12);
        check(sym_log[base] == 3'b111 && sym_log[base+1] == 3'b011 &&
              sym_log[base+2] == 3'b111 && sym_log[base+3] == 3'b000,
              "R4 impulse", int'({sym_log[base], sym_log[base+1]}), 8'o73);

        // R5: all-ones frame, then a new frame must start from zero state
        step(1, 1, 1, 1);
        for (int i = 0; i < 11; i++) step(1, 1, 0, 1);
        base = nsym;
        step(1, 1, 1, 1);
        step(0, 0, 0, 1);
        check(sym_log[base + 1] == 3'b111, "R5 sof clears history",
              int'(sym_log[base + 1]), 7);
        for (int i = 0; i < 11; i++) step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);

        // R8: idle bits without sof produce nothing
        base = nsym;
        for (int i = 0; i < 5; i++) step(1, 1, 0, 1);
        step(0, 0, 0, 1);
        check(nsym == base && out_valid == 0, "R8 idle discard", nsym - base, 0);

        // R9: restart mid-frame
        step(1, 1, 1, 1);
        for (int i = 0; i < 4; i++) step(1, 1, 0, 1);
        base = nsym;
        step(1, 1, 1, 1);
        step(1, 0, 0, 1);
        check(sym_log[base + 1] == 3'b111, "R9 restart clears history",
              int'(sym_log[base + 1]), 7);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        check(m_run == 0 && exp_q.size() == 0, "R9 restart frame completes",
              int'(m_run), 0);

        // random mix: sof collisions with frame end, backpressure
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, $urandom % 2, ($urandom % 16) == 0,
                 ($urandom % 5) < 3);
        end
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
        check(exp_q.size() == 0, "R1 all symbols delivered", exp_q.size(), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule